// File: doc/BRIEF.md
# Dual-Bank GPIO Controller with Masked Set/Clear Writes

This block controls 32 general-purpose pins from a plain 32-bit register bus made of an address, a write strobe, write data and combinational read data. The pins are split into two banks of 16. Each bank has an identical set of control registers, and the second bank sits 0x80 bytes above the first. Every control register is written with a masked word: the low half names bits to set and the high half names bits to clear. Software can therefore change one pin without reading the register first.

For each pin the controller produces a pad output level, a pad drive enable, pull-up and pull-down requests and an input-buffer enable. It can take the pad level from one of two auxiliary function inputs instead of the output-value register. Raw pin levels pass through a two-flop synchronizer, are gated by each pin's input enable, and are read back through the bus. The reset input is asynchronous and active low, and its release is synchronized inside the block.

Top module: `gpio_ctrl`

## Requirements
- R1: On a write to a control register, each data bit n (0..15) that is 1 sets bit n of that register, one clock after the write edge.
- R2: On a write to a control register, each data bit n+16 that is 1 clears bit n. If a pin has both its set bit and its clear bit at 1, the bit ends at 0.
- R3: A register bit whose set bit and clear bit are both 0 in a write keeps its value.
- R4: Address bit 7 selects the bank. Pins 0..15 use offsets 0x00..0x7F, and pins 16..31 use the same offsets plus 0x80. A write to one bank leaves the other bank unchanged.
- R5: Control-register offsets within a bank: pull-down enable 0x1C, pull-up enable 0x18, input enable 0x20, output enable 0x04, output value 0x00, open-drain enable 0x08, auxiliary select A 0x10, auxiliary select B 0x14.
- R6: A read returns the addressed register in bits 15:0 and zero in bits 31:16. Offset 0x30 is a read-only copy of the output-value register.
- R7: After reset every control register is 0, except input enable, which is 0xFFFF in both banks. After reset no pad is driven.
- R8: With open-drain disabled, pad_oe equals the output enable and pad_out is the selected source. With open-drain enabled, pad_out is 0, and pad_oe is 1 only when the output enable is 1 and the output value is 0.
- R9: The pad source is auxiliary input A if select A is set, otherwise auxiliary input B if select B is set, otherwise the output-value bit. Setting an output enable leaves both auxiliary selects unchanged.
- R10: Offset 0x34 returns the pin levels after a two-clock synchronizer, ANDed with the input enables. pad_ie follows the input-enable register.
- R11: A write to offsets 0x30, 0x34 or any unmapped offset changes no register. A read from an unmapped offset returns 0.
- R12: pad_pu and pad_pd follow the pull-up and pull-down enable registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data: set mask in bits 15:0, clear mask in bits 31:16 |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pin_in | input | 32 | Raw pin levels |
| aux_a_in | input | 32 | Auxiliary function A output levels |
| aux_b_in | input | 32 | Auxiliary function B output levels |
| pad_out | output | 32 | Pad output level |
| pad_oe | output | 32 | Pad drive enable |
| pad_pu | output | 32 | Pull-up request |
| pad_pd | output | 32 | Pull-down request |
| pad_ie | output | 32 | Input buffer enable |

## Verification
The masked write is tried with set-only, clear-only, set-and-clear on the same pin, and all-zero words. These separate a correct set/clear merge from a plain store, from a set-wins merge and from a merge that touches unnamed bits. Writes to one bank are followed by reads of the other bank, which exposes a wrong bank decode. Writes to read-only and unmapped offsets are also covered. Pad checks combine push-pull, open-drain with a high and a low value, and both auxiliary selects at once, which tells the source priority apart from the drive-enable rule. The level read is sampled after one clock and after two clocks, which pins the synchronizer depth and the input-enable mask.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  typedef enum logic [2:0] {
    REG_OUT  = 3'd0,
    REG_OE   = 3'd1,
    REG_OD   = 3'd2,
    REG_AUXA = 3'd3,
    REG_AUXB = 3'd4,
    REG_PU   = 3'd5,
    REG_PD   = 3'd6,
    REG_IE   = 3'd7
  } ctl_reg_e;

  localparam int NUM_CTL = 8;

  typedef struct packed {
    logic     hit_ctl;
    ctl_reg_e idx;
    logic     hit_rb;
    logic     hit_lvl;
  } decode_t;

  function automatic decode_t decode_offset(input logic [31:0] off);
    decode_t d;
    d.hit_ctl = 1'b0;
    d.idx     = REG_OUT;
    d.hit_rb  = 1'b0;
    d.hit_lvl = 1'b0;
    case (off)
      32'h00: begin d.hit_ctl = 1'b1; d.idx = REG_OUT;  end
      32'h04: begin d.hit_ctl = 1'b1; d.idx = REG_OE;   end
      32'h08: begin d.hit_ctl = 1'b1; d.idx = REG_OD;   end
      32'h10: begin d.hit_ctl = 1'b1; d.idx = REG_AUXA; end
      32'h14: begin d.hit_ctl = 1'b1; d.idx = REG_AUXB; end
      32'h18: begin d.hit_ctl = 1'b1; d.idx = REG_PU;   end
      32'h1C: begin d.hit_ctl = 1'b1; d.idx = REG_PD;   end
      32'h20: begin d.hit_ctl = 1'b1; d.idx = REG_IE;   end
      32'h30: d.hit_rb  = 1'b1;
      32'h34: d.hit_lvl = 1'b1;
      default: ;
    endcase
    return d;
  endfunction

  function automatic logic ctl_resets_high(input int idx);
    return (idx == int'(REG_IE));
  endfunction

endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q   <= '0;
      sync_out <= '0;
    end else begin
      meta_q   <= raw_in;
      sync_out <= meta_q;
    end
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int BANK_W = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  ctl_reg_e                          wr_idx,
  input  logic [BANK_W-1:0]                 set_mask,
  input  logic [BANK_W-1:0]                 clr_mask,
  output logic [NUM_CTL-1:0][BANK_W-1:0]    ctl_q
);

  for (genvar r = 0; r < NUM_CTL; r++) begin : g_reg
    localparam logic [BANK_W-1:0] RST_VAL = {BANK_W{ctl_resets_high(r)}};
    logic              reg_en;
    logic [BANK_W-1:0] reg_d;

    always_comb begin
      reg_en = wr_en && (wr_idx == ctl_reg_e'(r));
      reg_d  = (ctl_q[r] | set_mask) & ~clr_mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ctl_q[r] <= RST_VAL;
      end else if (reg_en) begin
        ctl_q[r] <= reg_d;
      end
    end

    // R1: set bits named in the low half (clear not also requested) read as 1 next cycle
    a_r1_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_idx == ctl_reg_e'(r)) |=>
        ((ctl_q[r] & $past(set_mask & ~clr_mask)) == $past(set_mask & ~clr_mask)));

    // R2: bits named in the high half read as 0 next cycle
    a_r2_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_idx == ctl_reg_e'(r)) |=> ((ctl_q[r] & $past(clr_mask)) == '0));

    // R3: bits named in neither half are unchanged
    a_r3_hold_unnamed: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((ctl_q[r] & ~$past(set_mask | clr_mask)) ==
                ($past(ctl_q[r]) & ~$past(set_mask | clr_mask))) ||
               !$past(wr_en && wr_idx == ctl_reg_e'(r)) && ctl_q[r] == $past(ctl_q[r]));
  end

endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] out_val,
  input  logic [W-1:0] out_en,
  input  logic [W-1:0] od_en,
  input  logic [W-1:0] aux_a_sel,
  input  logic [W-1:0] aux_b_sel,
  input  logic [W-1:0] aux_a_in,
  input  logic [W-1:0] aux_b_in,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe
);

  for (genvar p = 0; p < W; p++) begin : g_pin
    logic src;

    always_comb begin
      if (aux_a_sel[p]) begin
        src = aux_a_in[p];
      end else if (aux_b_sel[p]) begin
        src = aux_b_in[p];
      end else begin
        src = out_val[p];
      end
      if (od_en[p]) begin
        pad_out[p] = 1'b0;
        pad_oe[p]  = out_en[p] & ~src;
      end else begin
        pad_out[p] = src;
        pad_oe[p]  = out_en[p];
      end
    end
  end

  // R8: an open-drain pad that is driven only ever drives low
  a_r8_od_drives_low: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe & od_en) != '0) |-> ((pad_out & od_en) == '0));

  // R8: no pad is driven without its output enable
  a_r8_oe_gated: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe & ~out_en) == '0));

  // R9: auxiliary A has priority on push-pull pads
  a_r9_aux_a_priority: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_out & aux_a_sel & ~od_en) == (aux_a_in & aux_a_sel & ~od_en)));

endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS    = 32,
  parameter int BANK_W      = 16,
  parameter int ADDR_W      = 8,
  parameter int STRIDE_LOG2 = 7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic                  bus_we,
  input  logic [2*BANK_W-1:0]   bus_wdata,
  output logic [2*BANK_W-1:0]   bus_rdata,
  input  logic [NUM_PINS-1:0]   pin_in,
  input  logic [NUM_PINS-1:0]   aux_a_in,
  input  logic [NUM_PINS-1:0]   aux_b_in,
  output logic [NUM_PINS-1:0]   pad_out,
  output logic [NUM_PINS-1:0]   pad_oe,
  output logic [NUM_PINS-1:0]   pad_pu,
  output logic [NUM_PINS-1:0]   pad_pd,
  output logic [NUM_PINS-1:0]   pad_ie
);

  localparam int NUM_BANKS = NUM_PINS / BANK_W;
  localparam int DATA_W    = 2 * BANK_W;
  localparam int OFF_W     = STRIDE_LOG2;
  localparam int BSEL_W    = ADDR_W - STRIDE_LOG2;

  logic                 rst_sync_n;
  logic [BSEL_W-1:0]    bank_sel;
  logic [OFF_W-1:0]     bank_off;
  decode_t              dec;

  logic [NUM_BANKS-1:0][NUM_CTL-1:0][BANK_W-1:0] bank_ctl;
  logic [NUM_PINS-1:0]  out_val, out_en, od_en, aux_a_sel, aux_b_sel, in_en;
  logic [NUM_PINS-1:0]  pin_sync;

  gpio_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    bank_sel = bus_addr[ADDR_W-1:STRIDE_LOG2];
    bank_off = bus_addr[STRIDE_LOG2-1:0];
    dec      = decode_offset(32'(bank_off));
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic bank_wr;

    always_comb begin
      bank_wr = bus_we && dec.hit_ctl && (bank_sel == BSEL_W'(b));
    end

    gpio_bank #(.BANK_W(BANK_W)) u_bank (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .wr_en    (bank_wr),
      .wr_idx   (dec.idx),
      .set_mask (bus_wdata[BANK_W-1:0]),
      .clr_mask (bus_wdata[DATA_W-1:BANK_W]),
      .ctl_q    (bank_ctl[b])
    );

    assign out_val  [b*BANK_W +: BANK_W] = bank_ctl[b][REG_OUT];
    assign out_en   [b*BANK_W +: BANK_W] = bank_ctl[b][REG_OE];
    assign od_en    [b*BANK_W +: BANK_W] = bank_ctl[b][REG_OD];
    assign aux_a_sel[b*BANK_W +: BANK_W] = bank_ctl[b][REG_AUXA];
    assign aux_b_sel[b*BANK_W +: BANK_W] = bank_ctl[b][REG_AUXB];
    assign pad_pu   [b*BANK_W +: BANK_W] = bank_ctl[b][REG_PU];
    assign pad_pd   [b*BANK_W +: BANK_W] = bank_ctl[b][REG_PD];
    assign in_en    [b*BANK_W +: BANK_W] = bank_ctl[b][REG_IE];
  end

  gpio_in_sync #(.W(NUM_PINS)) u_in_sync (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .raw_in   (pin_in),
    .sync_out (pin_sync)
  );

  gpio_pad_mux #(.W(NUM_PINS)) u_pad_mux (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .out_val   (out_val),
    .out_en    (out_en),
    .od_en     (od_en),
    .aux_a_sel (aux_a_sel),
    .aux_b_sel (aux_b_sel),
    .aux_a_in  (aux_a_in),
    .aux_b_in  (aux_b_in),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe)
  );

  assign pad_ie = in_en;

  always_comb begin
    bus_rdata = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bank_sel == BSEL_W'(b)) begin
        if (dec.hit_ctl) begin
          bus_rdata[BANK_W-1:0] = bank_ctl[b][dec.idx];
        end else if (dec.hit_rb) begin
          bus_rdata[BANK_W-1:0] = bank_ctl[b][REG_OUT];
        end else if (dec.hit_lvl) begin
          bus_rdata[BANK_W-1:0] = pin_sync[b*BANK_W +: BANK_W] & in_en[b*BANK_W +: BANK_W];
        end
      end
    end
  end

  // R6: upper half of every read is zero
  a_r6_upper_zero: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_rdata[DATA_W-1:BANK_W] == '0));

  // R10: a pin whose input enable is off never reads back as high
  a_r10_level_masked: assert property (@(posedge clk) disable iff (!rst_sync_n)
    dec.hit_lvl |-> ((bus_rdata[BANK_W-1:0] & ~bank_ctl[0][REG_IE]) == '0 || bank_sel != '0));

endmodule

// File: tb/gpio_ctrl_tb_top.sv
module gpio_ctrl_tb_top;

  logic        clk;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in, aux_a_in, aux_b_in;
  logic [31:0] pad_out, pad_oe, pad_pu, pad_pd, pad_ie;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  gpio_ctrl dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_in    (pin_in),
    .aux_a_in  (aux_a_in),
    .aux_b_in  (aux_b_in),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .pad_pu    (pad_pu),
    .pad_pd    (pad_pd),
    .pad_ie    (pad_ie)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // tag, write addr, write data, read addr, expected read
  localparam int NV = 16;
  localparam logic [111:0] VEC [NV] = '{
    {"R1  ", 8'h00, 32'h0000_0005, 8'h00, 32'h0000_0005},
    {"R3  ", 8'h00, 32'h0000_0100, 8'h00, 32'h0000_0105},
    {"R2  ", 8'h00, 32'h0004_0000, 8'h00, 32'h0000_0101},
    {"R2  ", 8'h00, 32'h0001_0001, 8'h00, 32'h0000_0100},
    {"R4  ", 8'h80, 32'h0000_00F0, 8'h80, 32'h0000_00F0},
    {"R4  ", 8'h80, 32'h0000_0000, 8'h00, 32'h0000_0100},
    {"R11 ", 8'h30, 32'h0000_FFFF, 8'h30, 32'h0000_0100},
    {"R5  ", 8'h04, 32'h0000_0300, 8'h04, 32'h0000_0300},
    {"R5  ", 8'h08, 32'h0000_0200, 8'h08, 32'h0000_0200},
    {"R5  ", 8'h10, 32'h0000_0001, 8'h10, 32'h0000_0001},
    {"R5  ", 8'h14, 32'h0000_0002, 8'h14, 32'h0000_0002},
    {"R12 ", 8'h18, 32'h0000_0008, 8'h18, 32'h0000_0008},
    {"R12 ", 8'h1C, 32'h0000_0010, 8'h1C, 32'h0000_0010},
    {"R7  ", 8'h20, 32'h00FF_0000, 8'h20, 32'h0000_FF00},
    {"R11 ", 8'h24, 32'h0000_FFFF, 8'h24, 32'h0000_0000},
    {"R6  ", 8'h94, 32'hFFFF_FFFF, 8'h94, 32'h0000_0000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the next negedge, after the write edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_we    = 1'b1;
    @(negedge clk);
    bus_we    = 1'b0;
    bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    bus_addr  = '0;
    bus_we    = 1'b0;
    bus_wdata = '0;
    pin_in    = '0;
    aux_a_in  = '0;
    aux_b_in  = '0;
    rst_n     = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R7: reset state
    rd(8'h00, v); check("R7 out", v, 32'h0);
    rd(8'h20, v); check("R7 ie0", v, 32'h0000_FFFF);
    rd(8'hA0, v); check("R7 ie1", v, 32'h0000_FFFF);
    check("R7 pad_oe", pad_oe, 32'h0);
    check("R10 pad_ie", pad_ie, 32'hFFFF_FFFF);

    for (int k = 0; k < NV; k++) begin
      logic [111:0] e;
      logic [31:0]  tag;
      e   = VEC[k];
      tag = e[111:80];
      wr(e[79:72], e[71:40]);
      rd(e[39:32], v);
      check($sformatf("%s vec%0d", tag, k), v, e[31:0]);
    end

    // R8: pin8 push-pull high, pin9 open-drain with value 0
    check("R8 pp oe8", {31'b0, pad_oe[8]}, 32'h1);
    check("R8 pp out8", {31'b0, pad_out[8]}, 32'h1);
    check("R8 od oe9", {31'b0, pad_oe[9]}, 32'h1);
    check("R8 od out9", {31'b0, pad_out[9]}, 32'h0);
    wr(8'h00, 32'h0000_0200);
    check("R8 od release9", {31'b0, pad_oe[9]}, 32'h0);
    // R12
    check("R12 pu3", {31'b0, pad_pu[3]}, 32'h1);
    check("R12 pd4", {31'b0, pad_pd[4]}, 32'h1);
    check("R12 pu others", pad_pu & ~32'h8, 32'h0);

    // R9: auxiliary source selection and priority
    aux_a_in = 32'hFFFF_FFFF;
    aux_b_in = 32'h0;
    wr(8'h04, 32'h0000_0003);
    wr(8'h00, 32'h0000_0002);
    check("R9 auxA pin0", {31'b0, pad_out[0]}, 32'h1);
    check("R9 auxB pin1", {31'b0, pad_out[1]}, 32'h0);
    rd(8'h10, v); check("R9 oe keeps auxA", v, 32'h0000_0001);
    rd(8'h14, v); check("R9 oe keeps auxB", v, 32'h0000_0002);
    wr(8'h14, 32'h0000_0001);
    check("R9 A over B pin0", {31'b0, pad_out[0]}, 32'h1);

    // R10: synchronizer depth and input-enable mask
    pin_in = 32'hA5A5_0FF0;
    @(negedge clk);
    rd(8'h34, v); check("R10 one clock", v, 32'h0);
    @(negedge clk);
    rd(8'h34, v); check("R10 bank0 masked", v, 32'h0000_0F00);
    rd(8'hB4, v); check("R10 bank1", v, 32'h0000_A5A5);
    check("R10 pad_ie low", pad_ie[15:0], 32'h0000_FF00);

    // R11: write to level offset and an unmapped offset are ignored
    wr(8'h34, 32'hFFFF_FFFF);
    rd(8'h20, v); check("R11 ie after 0x34 write", v, 32'h0000_FF00);
    wr(8'h0C, 32'h0000_FFFF);
    rd(8'h0C, v); check("R11 unmapped read", v, 32'h0);
    rd(8'h00, v); check("R11 out unchanged", v, 32'h0000_0302);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule